// File: doc/BRIEF.md
# Event and Level Status Word with Masked Interrupt

This block gathers the status of a peripheral into one 32-bit word and turns it into a single interrupt request. Part of the word holds event flags: a one-cycle set pulse latches the flag, and it stays set until software clears it. Another part holds level flags that simply reflect conditions inside the peripheral, such as a queue being full or empty. The remaining positions are unused and always read as zero.

Software sees three registers through a plain register port: the status word (read-only), a write-one-to-clear register that drops event flags, and an enable register that chooses which status bits may raise the interrupt. The interrupt output is registered. It is the OR of every status bit ANDed with its enable bit.

The register map uses a 2-bit address: 0 selects the status word, 1 the clear register (which reads as zero), 2 the enable register, and 3 is spare (reads zero, and writes to it are dropped). Event flags occupy bits 29, 21 and 11 down to 0. Level flags occupy bits 20 down to 12.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset the status word reads zero with all level inputs low, the enable register reads zero, and `irq_o` is low.
- R2: A 1 on `set_i[k]` for an event position k (29, 21, 11..0) makes status bit k read 1 from the next clock edge on. The bit then stays 1 while nothing clears it.
- R3: A write of value V to address 1 clears every event bit where V has a 1. Event bits where V has a 0 keep their value.
- R4: When a set pulse and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R5: Status bits 20..12 read the same cycle's values of `live_i[20:12]`.
- R6: Unused status positions (31, 30, 28..22) always read 0. Set pulses on level or unused positions have no effect. Clearing writes have no effect on level or unused positions.
- R7: `irq_o` equals, one clock after, the OR over all k of status bit k AND enable bit k.
- R8: Writes to address 0 leave the status word unchanged.
- R9: A write to address 2 stores the data into the enable register, reading back from the next edge on. Enable bits at unused positions read 0.
- R10: Address 1 and address 3 read as zero, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 status, 1 clear, 2 enable, 3 spare) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | 32 | Combinational read data |
| set_i | input | 32 | Event set pulses, one per status position |
| live_i | input | 32 | Level condition inputs, one per status position |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take it that the set pulses, level inputs and write strobe are settled at every clock edge and hold no unknown values. They also take it that the write address is one of the four decoded codes. The stimulus changes every input at the falling edge and drives only defined values. Set pulses last exactly one cycle, and the bench drives set pulses on level and unused positions only to show that they are dropped. Level inputs are held steady across each edge where the interrupt is checked, so the one-cycle interrupt delay can be observed cleanly.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam logic [WORD_W-1:0] EVENT_POS = 32'h2020_0FFF;
  localparam logic [WORD_W-1:0] LEVEL_POS = 32'h001F_F000;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;
  logic         upd;

  // Set takes priority over clear; positions outside KEEP never hold a 1.
  always_comb begin
    q_d = KEEP & (set_i | (q_r & ~clr_i));
    upd = |(KEEP & (set_i | clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_d;
  end

  assign q_o = q_r;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (KEEP[k]) begin : g_kept
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k] |=> q_o[k]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && !set_i[k]) |=> !q_o[k]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[k] && !set_i[k]) |=> $stable(q_o[k]));
    end else begin : g_dropped
      assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !q_o[k]);
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  always_comb q_d = wdata_i & KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (we_i) q_r <= q_d;
  end

  assign q_o = q_r;

  assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == ($past(wdata_i) & KEEP)));
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  output logic         irq_o
);
  logic irq_d;
  logic irq_r;

  always_comb irq_d = |(status_i & enable_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_d;
  end

  assign irq_o = irq_r;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & enable_i)) |=> irq_o);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_i & enable_i)) |=> !irq_o);
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter logic [DW-1:0] EV_BITS = EVENT_POS,
  parameter logic [DW-1:0] LV_BITS = LEVEL_POS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [SEL_W-1:0]   rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  input  logic [DW-1:0]      set_i,
  input  logic [DW-1:0]      live_i,
  output logic               irq_o
);
  localparam logic [DW-1:0] USED = EV_BITS | LV_BITS;

  reg_sel_e      wsel;
  reg_sel_e      rsel;
  logic          clr_hit;
  logic          en_hit;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] ev_q;
  logic [DW-1:0] en_q;
  logic [DW-1:0] status;

  always_comb begin
    wsel    = reg_sel_e'(wr_addr_i);
    rsel    = reg_sel_e'(rd_addr_i);
    clr_hit = wr_en_i && (wsel == SEL_CLEAR);
    en_hit  = wr_en_i && (wsel == SEL_ENABLE);
    clr_vec = clr_hit ? wr_data_i : '0;
  end

  sticky_bank #(.W(DW), .KEEP(EV_BITS)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_i),
    .clr_i (clr_vec),
    .q_o   (ev_q)
  );

  enable_reg #(.W(DW), .KEEP(USED)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_hit),
    .wdata_i (wr_data_i),
    .q_o     (en_q)
  );

  always_comb status = ev_q | (live_i & LV_BITS);

  irq_combiner #(.W(DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .enable_i (en_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (rsel)
      SEL_STATUS: rd_data_o = status;
      SEL_ENABLE: rd_data_o = en_q;
      default:    rd_data_o = '0;
    endcase
  end

  assert_level_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == SEL_STATUS) |-> ((rd_data_o & LV_BITS) == (live_i & LV_BITS)));
  assert_status_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wsel == SEL_STATUS && set_i == '0) |=> ($stable(ev_q)));
  assert_clear_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == SEL_CLEAR || rsel == SEL_SPARE) |-> (rd_data_o == '0));
endmodule

// File: tb/tb_stat_irq_unit.sv
`timescale 1ns/1ps
module tb_stat_irq_unit;
  localparam logic [31:0] EV   = 32'h2020_0FFF;
  localparam logic [31:0] LV   = 32'h001F_F000;
  localparam logic [31:0] USED = EV | LV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [1:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [1:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic [31:0] set_i;
  logic [31:0] live_i;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  stat_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .set_i(set_i), .live_i(live_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk);
    set_i = s;
    @(negedge clk);
    set_i = '0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    rd_addr_i = '0; set_i = '0; live_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd2, v); check("R1 enable", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2/R6: walking set pulse over every position, then clear with all ones (R3)
    for (int b = 0; b < 32; b++) begin
      pulse(32'h1 << b);
      rd(2'd0, v); check("R2 R6 walking set", v, (32'h1 << b) & EV);
      @(negedge clk);
      rd(2'd0, v); check("R2 sticky hold", v, (32'h1 << b) & EV);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R3 clear all", v, 32'h0);
    end

    // R3 partial clear patterns
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'h5555_5555 : (p == 1) ? 32'hAAAA_AAAA :
            (p == 2) ? 32'h0000_00F0 : 32'h2000_0000;
      pulse(32'hFFFF_FFFF);
      wr(2'd1, pat);
      rd(2'd0, v); check("R3 partial clear", v, EV & ~pat);
      wr(2'd1, 32'hFFFF_FFFF);
    end

    // R4: set and clear on the same bit in the same cycle
    for (int q = 0; q < 3; q++) begin
      logic [31:0] bit_v;
      bit_v = (q == 0) ? 32'h2000_0000 : (q == 1) ? 32'h0020_0000 : 32'h0000_0020;
      @(negedge clk);
      set_i = bit_v; wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 32'hFFFF_FFFF;
      @(negedge clk);
      set_i = '0; wr_en_i = 1'b0;
      rd(2'd0, v); check("R4 set beats clear", v, bit_v);
      wr(2'd1, 32'hFFFF_FFFF);
    end

    // R5: level bits follow inputs in the same cycle
    for (int b = 0; b < 33; b++) begin
      @(negedge clk);
      live_i = (b == 32) ? 32'hFFFF_FFFF : (32'h1 << b);
      rd(2'd0, v); check("R5 level mirror", v, live_i & LV);
    end

    // R6: clear write does not touch level bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R6 clear ignores levels", v, LV);
    @(negedge clk); live_i = '0;

    // R8: status address is read-only
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R8 status read-only", v, 32'h0);
    pulse(32'h0000_0003);
    wr(2'd0, 32'h0);
    rd(2'd0, v); check("R8 write zero keeps flags", v, 32'h3);
    wr(2'd1, 32'hFFFF_FFFF);

    // R9: enable register readback
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R9 enable all", v, USED);
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, v); check("R9 enable pattern", v, 32'h1234_5678 & USED);

    // R10: clear and spare read zero, spare write no effect
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10 spare write", v, 32'h1234_5678 & USED);
    rd(2'd1, v); check("R10 clear reads zero", v, 32'h0);
    rd(2'd3, v); check("R10 spare reads zero", v, 32'h0);

    // R7: latency of interrupt
    wr(2'd2, 32'h0000_0008);
    @(negedge clk); set_i = 32'h8;
    @(negedge clk); set_i = '0;
    check("R7 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 irq after one cycle", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h8);
    check("R7 irq not dropped yet", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R7 irq dropped", {31'b0, irq_o}, 32'h0);

    // R7 sweep: one enable bit at a time, all sources active
    for (int b = 0; b < 32; b++) begin
      wr(2'd2, 32'h1 << b);
      @(negedge clk); live_i = 32'hFFFF_FFFF; set_i = 32'hFFFF_FFFF;
      @(negedge clk); set_i = '0;
      @(negedge clk);
      check("R7 irq per bit", {31'b0, irq_o}, {31'b0, USED[b]});
      live_i = '0;
      wr(2'd1, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R7 irq cleared", {31'b0, irq_o}, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule